// File: doc/BRIEF.md
# Cache Configuration Search Controller

This controller looks for a low energy-delay cache configuration for a single program phase. A `start_i` pulse loads a starting configuration, which is normally the most recently used one. The controller puts that configuration on `cfg_o`, and the cache runs the phase with it. At the end of each run the environment pulses `phase_end_i` and presents the run's power reading and cycle count. The controller turns these into an energy-delay figure. The frequency is fixed, so the figure is power × cycles × cycles. It then chooses the next candidate configuration or ends the search.

The configuration has three fields, and each field holds a power-of-two index: index 0 is the smallest setting and every step up doubles it. The search works on one field at a time, in a fixed order: capacity first, then ways, then line length. It keeps doubling the current field while the figure keeps improving. On the first run that fails to improve, it moves to the next field, starting again from the best configuration seen so far.

The search is limited to a fixed number of runs. When it ends, the controller raises `done_o` and drives the best configuration on `cfg_o`.

Top module: `cache_tune_fsm`

## Requirements
- R1: After reset, `cfg_o`, `best_cfg_o` and `best_edp_o` are 0, and `busy_o` and `done_o` are low.
- R2: While `busy_o` is low, a `start_i` pulse gives `cfg_o` = `init_cfg_i`, `busy_o` = 1 and `done_o` = 0 on the next cycle. While `busy_o` is high, `start_i` has no effect.
- R3: The figure for a run is `power_i` × `cycles_i` × `cycles_i`. If the true product needs more than EW (48) bits, the figure saturates to all ones.
- R4: Configuration fields are `cfg[1:0]` capacity, `cfg[3:2]` ways and `cfg[5:4]` line length. Each candidate differs from the best configuration by +1 in exactly one field. Fields are searched in the order capacity, ways, line length.
- R5: A run whose figure is greater than or equal to the best figure ends the search on the current field. The next candidate then steps a later field, starting from the best configuration.
- R6: A field already at its maximum index (2 by default) is skipped and gets no run. If no field remains that can be stepped, the search ends.
- R7: A search never uses more than MAX_RUNS (3) runs, counting the starting configuration.
- R8: The first run of a search always becomes the best. After that, the best configuration and best figure change only when a run's figure is strictly lower.
- R9: When the search ends, `done_o` = 1, `busy_o` = 0, and `cfg_o` equals `best_cfg_o` on the cycle after the final report.
- R10: `phase_end_i` has no effect while `busy_o` is low. If `start_i` and `phase_end_i` arrive in the same cycle while busy, the report is processed and the start is ignored.
- R11: While busy, `cfg_o` changes only on the cycle after a `phase_end_i` report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a search pulse |
| init_cfg_i | input | 6 | Starting configuration (must be legal) |
| phase_end_i | input | 1 | End-of-run report pulse |
| power_i | input | 16 | Power reading for the run just ended |
| cycles_i | input | 24 | Cycle count for the run just ended |
| cfg_o | output | 6 | Configuration applied to the cache |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished, result valid |
| best_cfg_o | output | 6 | Lowest-figure configuration seen |
| best_edp_o | output | 48 | Figure of `best_cfg_o` |

## Verification
The start request and the end-of-run report can arrive in the same clock cycle. While a search is running, the bench provokes this by raising `start_i`, with a different starting configuration, together with `phase_end_i`. It then checks that the next candidate follows the reference search exactly, which shows the report was used and the start was ignored. The bench also sends a report with no search running and checks at the outputs that nothing moves.

// File: rtl/cache_tune_fsm.sv
module cache_tune_fsm #(
  parameter int PW       = 16,
  parameter int CW       = 24,
  parameter int EW       = 48,
  parameter int FLD      = 2,
  parameter int SZ_MAX   = 2,
  parameter int AS_MAX   = 2,
  parameter int LN_MAX   = 2,
  parameter int MAX_RUNS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [3*FLD-1:0]     init_cfg_i,
  input  logic                 phase_end_i,
  input  logic [PW-1:0]        power_i,
  input  logic [CW-1:0]        cycles_i,
  output logic [3*FLD-1:0]     cfg_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [3*FLD-1:0]     best_cfg_o,
  output logic [EW-1:0]        best_edp_o
);
  localparam int CFGW = 3*FLD;
  localparam int FW   = PW + 2*CW;
  localparam int JW   = $clog2(MAX_RUNS+1);
  localparam logic [FLD-1:0] FMAX [3] = '{FLD'(SZ_MAX), FLD'(AS_MAX), FLD'(LN_MAX)};

  logic            busy_q, done_q;
  logic [1:0]      p_q;
  logic [JW-1:0]   j_q;
  logic [CFGW-1:0] cfg_q, best_q;
  logic [EW-1:0]   best_edp_q;

  logic [FW-1:0]   prod;
  logic [EW-1:0]   edp;
  logic            report, better, finish;
  logic [CFGW-1:0] best_n, cand;
  logic [1:0]      pstart, q;

  assign report = busy_q & phase_end_i;
  assign prod   = FW'(power_i) * FW'(cycles_i) * FW'(cycles_i);
  assign edp    = (|prod[FW-1:EW]) ? {EW{1'b1}} : prod[EW-1:0];
  assign better = (j_q == JW'(1)) || (edp < best_edp_q);

  always_comb begin
    best_n = better ? cfg_q : best_q;
    pstart = better ? p_q : p_q + 2'd1;
    q = 2'd3;
    for (int k = 2; k >= 0; k--)
      if (k >= int'(pstart) && best_n[k*FLD +: FLD] < FMAX[k]) q = 2'(k);
    cand = best_n;
    if (q != 2'd3) cand[int'(q)*FLD +: FLD] = best_n[int'(q)*FLD +: FLD] + 1'b1;
  end

  assign finish = (q == 2'd3) || (j_q == JW'(MAX_RUNS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      p_q        <= '0;
      j_q        <= '0;
      cfg_q      <= '0;
      best_q     <= '0;
      best_edp_q <= '0;
    end else if (report) begin
      if (better) begin
        best_q     <= cfg_q;
        best_edp_q <= edp;
      end
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        cfg_q  <= best_n;
      end else begin
        cfg_q <= cand;
        p_q   <= q;
        j_q   <= j_q + JW'(1);
      end
    end else if (start_i && !busy_q) begin
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      cfg_q      <= init_cfg_i;
      p_q        <= '0;
      j_q        <= JW'(1);
      best_edp_q <= {EW{1'b1}};
    end
  end

  assign cfg_o      = cfg_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign best_cfg_o = best_q;
  assign best_edp_o = best_edp_q;
endmodule

// File: rtl/cache_tune_chk.sv
module cache_tune_chk #(
  parameter int EW     = 48,
  parameter int FLD    = 2,
  parameter int SZ_MAX = 2,
  parameter int AS_MAX = 2,
  parameter int LN_MAX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             phase_end_i,
  input logic [3*FLD-1:0] cfg_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [3*FLD-1:0] best_cfg_o,
  input logic [EW-1:0]    best_edp_o
);
  assert_not_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  assert_done_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cfg_o == best_cfg_o);
  assert_done_after_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(phase_end_i));
  assert_hold_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !phase_end_i |=> $stable(cfg_o));
  assert_idle_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && phase_end_i && !start_i |=> $stable(cfg_o) && !busy_o);
  assert_best_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> best_edp_o <= $past(best_edp_o));
  assert_legal_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[FLD-1:0] <= FLD'(SZ_MAX));
  assert_legal_ways_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[2*FLD-1:FLD] <= FLD'(AS_MAX));
  assert_legal_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[3*FLD-1:2*FLD] <= FLD'(LN_MAX));
endmodule

bind cache_tune_fsm cache_tune_chk #(
  .EW(EW), .FLD(FLD), .SZ_MAX(SZ_MAX), .AS_MAX(AS_MAX), .LN_MAX(LN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_end_i(phase_end_i),
  .cfg_o(cfg_o), .busy_o(busy_o), .done_o(done_o),
  .best_cfg_o(best_cfg_o), .best_edp_o(best_edp_o)
);

// File: tb/sim_cache_tune_fsm.sv
module sim_cache_tune_fsm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  init_cfg_i = '0;
  logic        phase_end_i = 1'b0;
  logic [15:0] power_i = '0;
  logic [23:0] cycles_i = '0;
  logic [5:0]  cfg_o, best_cfg_o;
  logic        busy_o, done_o;
  logic [47:0] best_edp_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [15:0] pw [64];
  logic [23:0] cy [64];

  cache_tune_fsm u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned edp_f(logic [15:0] p, logic [23:0] c);
    longint unsigned r = longint'(p) * longint'(c) * longint'(c);
    return (r >= 64'h0001_0000_0000_0000) ? 64'h0000_FFFF_FFFF_FFFF : r;
  endfunction

  function automatic int fld(logic [5:0] c, int k);
    return int'(c[k*2 +: 2]);
  endfunction

  task automatic session(logic [5:0] init, bit collide);
    logic [5:0] cur = init, best = init;
    longint unsigned bedp = 0, e;
    int p = 0, j = 1, q;
    bit fin = 1'b0, better;
    @(negedge clk); start_i = 1'b1; init_cfg_i = init;
    @(negedge clk); start_i = 1'b0;
    chk("R2 busy after start", busy_o, 1);
    chk("R2 cfg after start", cfg_o, init);
    chk("R2 done cleared", done_o, 0);
    while (!fin) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      chk("R11 cfg held between reports", cfg_o, cur);
      e = edp_f(pw[cur], cy[cur]);
      phase_end_i = 1'b1; power_i = pw[cur]; cycles_i = cy[cur];
      if (collide) begin start_i = 1'b1; init_cfg_i = ~cur & 6'h15; end
      @(negedge clk);
      phase_end_i = 1'b0; start_i = 1'b0;
      better = (j == 1) || (e < bedp);
      if (better) begin best = cur; bedp = e; end else p++;
      q = 3;
      for (int k = 2; k >= 0; k--) if (k >= p && fld(best, k) < 2) q = k;
      if (q == 3 || j == 3) fin = 1'b1;
      else begin
        cur = best; cur[q*2 +: 2] = cur[q*2 +: 2] + 2'd1; p = q; j++;
        chk(collide ? "R10 report wins over start" : "R4 next candidate", cfg_o, cur);
      end
    end
    chk("R9 done", done_o, 1);
    chk("R9 not busy", busy_o, 0);
    chk("R8 best cfg", best_cfg_o, best);
    chk("R3 best edp", best_edp_o, bedp);
    chk("R9 cfg shows best", cfg_o, best);
    chk("R7 run count bound", j <= 3, 1);
  endtask

  task automatic fill_random(int pmax, int cmax);
    for (int i = 0; i < 64; i++) begin
      pw[i] = 16'($urandom_range(1, pmax));
      cy[i] = 24'($urandom_range(1, cmax));
    end
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg", cfg_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 best cfg", best_cfg_o, 0);
    chk("R1 best edp", best_edp_o, 0);

    phase_end_i = 1'b1; power_i = 16'd9; cycles_i = 24'd9;
    @(negedge clk); phase_end_i = 1'b0;
    chk("R10 idle report ignored busy", busy_o, 0);
    chk("R10 idle report ignored edp", best_edp_o, 0);

    fill_random(255, 4095);
    pw[6'b101010] = 16'hFFFF; cy[6'b101010] = 24'hFFFFFF;
    session(6'b101010, 1'b0);
    chk("R3 saturation", best_edp_o, 48'hFFFF_FFFF_FFFF);
    chk("R6 no step from all-max", cfg_o, 6'b101010);

    for (int i = 0; i < 64; i++) begin pw[i] = 16'd1; cy[i] = 24'd10; end
    session(6'b000000, 1'b0);
    chk("R8 tie keeps first", best_cfg_o, 0);

    fill_random(255, 4095);
    @(negedge clk); start_i = 1'b1; init_cfg_i = 6'b000001;
    @(negedge clk); start_i = 1'b1; init_cfg_i = 6'b010000;
    @(negedge clk); start_i = 1'b0;
    chk("R2 start ignored while busy", cfg_o, 6'b000001);
    phase_end_i = 1'b1; power_i = 16'd1; cycles_i = 24'd1;
    @(negedge clk); phase_end_i = 1'b0;
    while (busy_o) begin
      phase_end_i = 1'b1; power_i = 16'd500; cycles_i = 24'd500;
      @(negedge clk); phase_end_i = 1'b0;
    end
    chk("R5 increase keeps start cfg", best_cfg_o, 6'b000001);

    session(6'b000100, 1'b1);
    for (int t = 0; t < 40; t++) begin
      logic [5:0] ic;
      fill_random(255, 4095);
      ic = {2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)), 2'($urandom_range(0, 2))};
      session(ic, t % 7 == 3);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule